// File: doc/BRIEF.md
# Time-Slave Cycle Timer for Time-Triggered CAN

This block keeps cycle-relative time for a time-triggered CAN node that runs as a time slave. A free-running 16-bit local time counter comes in from outside. The frame decoder supplies a start-of-frame strobe and a strobe for a reference frame that completed without error, together with the 6-bit cycle count carried in that frame. At each start of frame the block stores a provisional timestamp. When a reference frame is accepted, that stamp becomes the reference mark and the received cycle count is loaded. Cycle time is local time minus the reference mark, modulo 2^16.

Seven programmable time marks are compared against cycle time. Six of them drive transmit triggers for the data slots, and the seventh belongs to the reference slot. Each trigger is a single-clock pulse. Two watch thresholds guard against a missing reference. An initial threshold is active until the first reference is accepted, and a normal threshold is active after that. Reaching the active threshold sets a sticky error flag. A gap-status input is held pending and is reported as a one-clock interrupt when the current basic cycle ends, which is the next accepted reference.

Top module: `ttcan_slave_timer`

## Requirements
- R1: After reset, ref_mark_o, cycle_cnt_o, tx_trig_o, wt_err_o, synced_o and gap_irq_o are all zero, and the initial watch threshold is active.
- R2: A sof_i strobe stores local_time_i as a provisional stamp only. Without ref_ok_i, ref_mark_o does not change.
- R3: In a cycle with ref_ok_i high, ref_mark_o takes the most recent stamp stored by a sof_i in an earlier cycle, and cycle_cnt_o takes ref_cycle_i. Both outputs show the new values in the next cycle.
- R4: cycle_time_o equals local_time_i minus ref_mark_o modulo 2^16, combinationally.
- R5: cycle_cnt_o changes only on ref_ok_i. It is never incremented locally.
- R6: Mark k occupies bits [16k+15:16k] of mark_val_i. Bits 0 to 5 of tx_trig_o serve the data slots and bit 6 serves the reference slot. If mark k is enabled and cycle_time_o equals the mark in a cycle without ref_ok_i, then tx_trig_o[k] pulses for one clock in the next cycle. The mark then stays silent until the next ref_ok_i re-arms it.
- R7: A mark whose bit in mark_en_i is low never raises its trigger.
- R8: synced_o rises in the cycle after the first ref_ok_i and stays high until reset. The active watch threshold is init_watch_i while synced_o is low and norm_watch_i while it is high.
- R9: If cycle_time_o equals the active watch threshold in a cycle without ref_ok_i, wt_err_o is set in the next cycle and stays set. A cycle with wt_clr_i high clears it, unless a new set happens in that same cycle, in which case the set wins.
- R10: A high gap_i makes a gap report pending. In a cycle with ref_ok_i high, if a report is pending or gap_i is high, gap_irq_o pulses for one clock in the next cycle and the pending report is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| local_time_i | input | 16 | Free-running local time |
| sof_i | input | 1 | Start-of-frame strobe |
| ref_ok_i | input | 1 | Reference frame accepted strobe |
| ref_cycle_i | input | 6 | Cycle count carried in the reference frame |
| mark_val_i | input | 112 | Seven time marks, mark k at bits [16k+15:16k] |
| mark_en_i | input | 7 | Per-mark enable |
| init_watch_i | input | 16 | Watch threshold before the first reference |
| norm_watch_i | input | 16 | Watch threshold after the first reference |
| gap_i | input | 1 | Next-is-gap status |
| wt_clr_i | input | 1 | Write-one-to-clear for the watch error |
| cycle_time_o | output | 16 | Cycle-relative time |
| ref_mark_o | output | 16 | Committed reference mark |
| cycle_cnt_o | output | 6 | Cycle count |
| tx_trig_o | output | 7 | Trigger pulses (0..5 data slots, 6 reference slot) |
| wt_err_o | output | 1 | Sticky watch-trigger error |
| synced_o | output | 1 | High once the normal watch threshold is active |
| gap_irq_o | output | 1 | Gap interrupt pulse at the end of the basic cycle |

## Verification
The main function is first tried with no reference at all. This shows that the initial threshold alone raises the error, with cycle time equal to raw local time. Random reference periods follow, some shorter and some longer than the normal threshold, with frames that start and are then dropped. Dropped frames separate the commit-on-success behaviour from committing the stamp at start of frame. The long periods show that the normal threshold has taken over. Local time starts just below the wrap point, which tests modulo subtraction. Random marks and enables, changed halfway through the run, exercise single-pulse triggering and the effect of the enable bits.

// File: rtl/ttcan_ts_pkg.sv
package ttcan_ts_pkg;
  localparam int unsigned TIME_W    = 16;
  localparam int unsigned CNT_W     = 6;
  localparam int unsigned NUM_MARKS = 7;
  localparam int unsigned REF_MARK  = NUM_MARKS - 1; // reference slot index
endpackage

// File: rtl/ts_ref_tracker.sv
module ts_ref_tracker #(
  parameter int unsigned TIME_W = 16,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] local_time_i,
  input  logic              sof_i,
  input  logic              ref_ok_i,
  input  logic [CNT_W-1:0]  ref_cycle_i,
  input  logic              gap_i,
  output logic [TIME_W-1:0] ref_mark_o,
  output logic [CNT_W-1:0]  cycle_cnt_o,
  output logic              synced_o,
  output logic              gap_irq_o
);
  logic [TIME_W-1:0] sof_stamp_q, ref_mark_q;
  logic [CNT_W-1:0]  cycle_cnt_q;
  logic              synced_q, gap_pend_q, gap_irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_stamp_q <= '0;
      ref_mark_q  <= '0;
      cycle_cnt_q <= '0;
      synced_q    <= 1'b0;
      gap_pend_q  <= 1'b0;
      gap_irq_q   <= 1'b0;
    end else begin
      if (sof_i) sof_stamp_q <= local_time_i;
      if (ref_ok_i) begin
        ref_mark_q  <= sof_stamp_q;  // stamp from an earlier SOF
        cycle_cnt_q <= ref_cycle_i;  // slave copies, never counts
        synced_q    <= 1'b1;
        gap_irq_q   <= gap_pend_q | gap_i;
        gap_pend_q  <= 1'b0;
      end else begin
        gap_irq_q   <= 1'b0;
        gap_pend_q  <= gap_pend_q | gap_i;
      end
    end
  end

  assign ref_mark_o  = ref_mark_q;
  assign cycle_cnt_o = cycle_cnt_q;
  assign synced_o    = synced_q;
  assign gap_irq_o   = gap_irq_q;

  // R2
  ref_mark_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_i |=> $stable(ref_mark_q));
  // R5
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_i |=> $stable(cycle_cnt_q));
  // R3
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ok_i |=> cycle_cnt_q == $past(ref_cycle_i));
  // R8
  synced_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synced_q |=> synced_q);
  // R10
  gap_irq_only_at_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_i |=> !gap_irq_q);
endmodule

// File: rtl/ts_mark_unit.sv
module ts_mark_unit #(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] cycle_time_i,
  input  logic [TIME_W-1:0] mark_i,
  input  logic              en_i,
  input  logic              restart_i,
  output logic              trig_o
);
  logic fired_q, trig_q, hit;

  assign hit = en_i && !fired_q && !restart_i && (cycle_time_i == mark_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= hit;
      if (restart_i)  fired_q <= 1'b0;
      else if (hit)   fired_q <= 1'b1;
    end
  end

  assign trig_o = trig_q;

  // R6
  trig_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);
  // R7
  trig_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !trig_q);
endmodule

// File: rtl/ts_watch.sv
module ts_watch #(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] cycle_time_i,
  input  logic [TIME_W-1:0] init_thr_i,
  input  logic [TIME_W-1:0] norm_thr_i,
  input  logic              synced_i,
  input  logic              restart_i,
  input  logic              clr_i,
  output logic              err_o
);
  logic [TIME_W-1:0] thr;
  logic              err_q, set;

  assign thr = synced_i ? norm_thr_i : init_thr_i;
  assign set = !restart_i && (cycle_time_i == thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (set)   err_q <= 1'b1;   // set wins over clear
    else if (clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
  // R9
  err_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && cycle_time_i != init_thr_i && cycle_time_i != norm_thr_i) |=> !err_q);
endmodule

// File: rtl/ttcan_slave_timer.sv
module ttcan_slave_timer
  import ttcan_ts_pkg::*;
#(
  parameter int unsigned T_W = TIME_W,
  parameter int unsigned C_W = CNT_W,
  parameter int unsigned N_M = NUM_MARKS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [T_W-1:0]   local_time_i,
  input  logic             sof_i,
  input  logic             ref_ok_i,
  input  logic [C_W-1:0]   ref_cycle_i,
  input  logic [N_M*T_W-1:0] mark_val_i,
  input  logic [N_M-1:0]   mark_en_i,
  input  logic [T_W-1:0]   init_watch_i,
  input  logic [T_W-1:0]   norm_watch_i,
  input  logic             gap_i,
  input  logic             wt_clr_i,
  output logic [T_W-1:0]   cycle_time_o,
  output logic [T_W-1:0]   ref_mark_o,
  output logic [C_W-1:0]   cycle_cnt_o,
  output logic [N_M-1:0]   tx_trig_o,
  output logic             wt_err_o,
  output logic             synced_o,
  output logic             gap_irq_o
);
  logic [T_W-1:0] ref_mark, cycle_time;
  logic           synced;

  ts_ref_tracker #(.TIME_W(T_W), .CNT_W(C_W)) u_ref (
    .clk_i, .rst_ni, .local_time_i, .sof_i, .ref_ok_i, .ref_cycle_i, .gap_i,
    .ref_mark_o(ref_mark), .cycle_cnt_o, .synced_o(synced), .gap_irq_o
  );

  assign cycle_time = local_time_i - ref_mark; // wraps mod 2^T_W

  for (genvar k = 0; k < N_M; k++) begin : g_mark
    ts_mark_unit #(.TIME_W(T_W)) u_mark (
      .clk_i, .rst_ni,
      .cycle_time_i(cycle_time),
      .mark_i(mark_val_i[k*T_W +: T_W]),
      .en_i(mark_en_i[k]),
      .restart_i(ref_ok_i),
      .trig_o(tx_trig_o[k])
    );
  end

  ts_watch #(.TIME_W(T_W)) u_watch (
    .clk_i, .rst_ni,
    .cycle_time_i(cycle_time),
    .init_thr_i(init_watch_i),
    .norm_thr_i(norm_watch_i),
    .synced_i(synced),
    .restart_i(ref_ok_i),
    .clr_i(wt_clr_i),
    .err_o(wt_err_o)
  );

  assign cycle_time_o = cycle_time;
  assign ref_mark_o   = ref_mark;
  assign synced_o     = synced;

  // R4
  cycle_time_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (local_time_i == ref_mark_o) |-> (cycle_time_o == '0));
endmodule

// File: tb/ttcan_slave_timer_tb.sv
module ttcan_slave_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] lt = '0;
  logic sof = 0, ok = 0, gap = 0, clr = 0;
  logic [5:0] rc = '0;
  logic [NM*16-1:0] marks = '0;
  logic [NM-1:0] en = '0;
  logic [15:0] iw = 16'd600, nw = 16'd330;
  logic [15:0] ct_o, rm_o;
  logic [5:0]  cc_o;
  logic [NM-1:0] trig_o;
  logic err_o, syn_o, girq_o;

  int tests = 0, fails = 0;

  // model state
  logic [15:0] m_stamp, m_ref;
  logic [5:0]  m_cnt;
  logic [NM-1:0] m_fired, m_trig;
  logic m_syn, m_err, m_pend, m_girq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ttcan_slave_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .local_time_i(lt), .sof_i(sof), .ref_ok_i(ok),
    .ref_cycle_i(rc), .mark_val_i(marks), .mark_en_i(en), .init_watch_i(iw),
    .norm_watch_i(nw), .gap_i(gap), .wt_clr_i(clr), .cycle_time_o(ct_o),
    .ref_mark_o(rm_o), .cycle_cnt_o(cc_o), .tx_trig_o(trig_o), .wt_err_o(err_o),
    .synced_o(syn_o), .gap_irq_o(girq_o)
  );

  task automatic chk(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mark_of(input int k);
    return marks[k*16 +: 16];
  endfunction

  task automatic model_reset();
    m_stamp = '0; m_ref = '0; m_cnt = '0; m_fired = '0; m_trig = '0;
    m_syn = 0; m_err = 0; m_pend = 0; m_girq = 0;
  endtask

  // next state from the inputs about to be sampled
  task automatic model_step();
    logic [15:0] ct, thr;
    logic set;
    ct  = lt - m_ref;
    thr = m_syn ? nw : iw;
    set = !ok && (ct == thr);
    if (set) m_err = 1;
    else if (clr) m_err = 0;
    if (ok) begin
      m_trig = '0; m_fired = '0;
      m_girq = m_pend | gap; m_pend = 0;
      m_ref = m_stamp; m_cnt = rc; m_syn = 1;
    end else begin
      for (int k = 0; k < NM; k++)
        m_trig[k] = en[k] && !m_fired[k] && (ct == mark_of(k));
      m_fired |= m_trig;
      m_pend |= gap; m_girq = 0;
    end
    if (sof) m_stamp = lt;
  endtask

  task automatic compare();
    chk(ct_o == lt - m_ref, "R4 cycle time", ct_o, lt - m_ref);
    chk(rm_o == m_ref, "R2/R3 reference mark", rm_o, m_ref);
    chk(cc_o == m_cnt, "R5 cycle count", cc_o, m_cnt);
    chk(trig_o == m_trig, "R6 triggers", trig_o, m_trig);
    chk((trig_o & ~en) == '0 || trig_o != m_trig, "R7 disabled mark fired", trig_o, m_trig);
    chk(syn_o == m_syn, "R8 synced", syn_o, m_syn);
    chk(err_o == m_err, "R9 watch error", err_o, m_err);
    chk(girq_o == m_girq, "R10 gap irq", girq_o, m_girq);
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic rand_marks();
    for (int k = 0; k < NM; k++) marks[k*16 +: 16] = 16'($urandom_range(10, 300));
    en = NM'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed, next_sof, ok_delay, cyc;
    logic pending_ok;
    seed = $urandom(32'd4242);
    model_reset();
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    chk(rm_o == 0 && cc_o == 0, "R1 mark/count", {rm_o, 10'd0, cc_o}, 0);
    chk(trig_o == 0 && !err_o && !syn_o && !girq_o, "R1 flags", {trig_o, err_o, syn_o, girq_o}, 0);
    rst_n = 1;
    rand_marks();
    // directed: no reference, initial watch threshold must trip (R9, R8)
    for (int i = 0; i < 700; i++) begin
      lt = lt + 16'd1;
      tick();
    end
    chk(err_o == 1'b1, "R9 initial threshold tripped", err_o, 1);
    chk(syn_o == 1'b0, "R8 still unsynced", syn_o, 0);
    clr = 1; lt = lt + 16'd1; tick(); clr = 0;
    chk(err_o == 1'b0, "R9 cleared", err_o, 0);
    // random phase, local time near wrap
    lt = 16'hFF00;
    next_sof = 5; ok_delay = -1; cyc = 0; pending_ok = 0;
    for (int i = 0; i < 40000; i++) begin
      lt = lt + 16'd1;
      sof = 0; ok = 0;
      gap = ($urandom_range(0, 199) == 0);
      clr = ($urandom_range(0, 149) == 0);
      rc = 6'($urandom);
      if (i == 20000) rand_marks();
      if (cyc == next_sof) begin
        sof = 1; cyc = 0;
        next_sof = $urandom_range(220, 420);
        ok_delay = $urandom_range(20, 60);
        pending_ok = ($urandom_range(0, 4) != 0); // some frames dropped
      end else begin
        cyc++;
        if (pending_ok && cyc == ok_delay) begin ok = 1; pending_ok = 0; end
      end
      tick();
    end
    // directed: SOF without accept leaves mark and count (R2, R5)
    sof = 0; ok = 0; gap = 0; clr = 0;
    begin
      logic [15:0] rm_before; logic [5:0] cc_before;
      rm_before = rm_o; cc_before = cc_o;
      sof = 1; lt = lt + 16'd1; tick(); sof = 0;
      for (int i = 0; i < 5; i++) begin lt = lt + 16'd1; tick(); end
      chk(rm_o == rm_before, "R2 dropped frame keeps mark", rm_o, rm_before);
      chk(cc_o == cc_before, "R5 count not incremented", cc_o, cc_before);
      // accept commits the stamp taken at SOF (R3)
      ok = 1; rc = 6'd63; gap = 1; lt = lt + 16'd1; tick(); ok = 0; gap = 0;
      chk(rm_o == m_ref && cc_o == 6'd63, "R3 commit", {rm_o, 10'd0, cc_o}, {m_ref, 10'd0, 6'd63});
      chk(girq_o == 1'b1, "R10 gap irq pulse", girq_o, 1);
      lt = lt + 16'd1; tick();
      chk(girq_o == 1'b0, "R10 gap irq single", girq_o, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule